// File: doc/BRIEF.md
# Period-Match Timer with PWM Output

This block is an 8-bit interval timer that counts prescaled clock ticks and compares the count with a programmable period value. When the count equals the period, the next tick returns the count to zero. That event is called a period match. Period matches are counted by a 4-bit postscaler, which raises a sticky interrupt flag after a selectable number of matches.

The period match also frames a single-output pulse-width modulator. Each match opens a new PWM cycle. A duty value latched at that moment sets how many timer ticks the output stays high. Software drives the block through one write port with a small register select, and clears the flag through a dedicated strobe.

Top module: `pmt_timer_pwm`

## Requirements
- R1: After reset, the PWM output and the interrupt flag are low. The timer count, prescaler and postscaler are zero. The period register holds 255, the duty register holds 0, counting is disabled and PWM mode is off.
- R2: A write with `wr_en` high updates one register, chosen by `wr_sel`: 0 is period, 1 is duty, 2 is control, 3 is mode and 4 is the timer count. Select codes 5 to 7 have no effect.
- R3: While the control enable bit (control bit 2) is 0, the timer, the prescaler and the PWM output hold their values.
- R4: The control prescale field, bits 1:0, sets the tick rate. A value of 0 gives one tick per clock, 1 gives one tick per 4 clocks, and 2 or 3 give one tick per 16 clocks.
- R5: On a tick with the count equal to the period register, the count becomes 0. A full timer cycle therefore lasts (period + 1) × prescale clocks.
- R6: With control bits 6:3 equal to n, the flag is set on every (n+1)-th period match. It stays set until `irq_clr` is pulsed. A match that sets the flag takes priority over a clear in the same cycle.
- R7: A write to the timer count loads the written value. Both a timer write and a control write clear the prescaler and the postscaler, and no tick happens in the cycle of either write.
- R8: PWM operation is on when mode bits 3:2 are 2'b11. With any other mode value, the PWM output is driven low from the second clock edge after the mode write.
- R9: In PWM mode, each period match copies the duty register into a shadow latch and drives the output high if the duty is nonzero. The output falls on the tick where the count becomes the shadow value, so it stays high for duty × prescale clocks.
- R10: A duty of 0 keeps the output low for the whole cycle. A duty above the period register keeps it high for the whole cycle.
- R11: A duty write in the middle of a PWM cycle does not change that cycle. It takes effect from the next period match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 8 | Write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| pwm_o | output | 1 | PWM output |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with its default widths: an 8-bit count, a 4-bit postscaler and a 1:16 largest prescale. Because the period can be set to small values, it sweeps periods 0, 1, 2 and 5 against all three prescale choices and against duties of 0, 1, equal to the period, one above the period and well above it. It predicts every clock of the PWM output and the flag arithmetically from (period + 1) × prescale. The default period of 255 is reached in one directed run. Further directed runs cover the enable freeze, postscaler clearing by a control write, a duty change in the middle of a cycle, and leaving PWM mode.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
   typedef enum logic [2:0] {
      REG_PERIOD = 3'd0,
      REG_DUTY   = 3'd1,
      REG_CTRL   = 3'd2,
      REG_MODE   = 3'd3,
      REG_COUNT  = 3'd4
   } pmt_reg_e;

   localparam int CTL_PRE_LSB  = 0;
   localparam int CTL_PRE_W    = 2;
   localparam int CTL_EN_BIT   = 2;
   localparam int CTL_POST_LSB = 3;
   localparam int MODE_SEL_LSB = 2;
endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
   parameter int SEL_W    = 2,
   parameter int STEP_LOG = 2,
   parameter int MAX_LOG  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             clr_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   if (MAX_LOG == 0) begin : g_direct
      assign tick_o = en_i && !clr_i;
   end else begin : g_div
      logic [MAX_LOG-1:0] cnt_q;
      logic [MAX_LOG-1:0] mask;
      logic               last;

      always_comb begin
         int lg;
         lg = int'(sel_i) * STEP_LOG;
         if (lg > MAX_LOG) lg = MAX_LOG;
         for (int b = 0; b < MAX_LOG; b++) mask[b] = (b < lg);
      end

      assign last   = (cnt_q == mask);
      assign tick_o = en_i && !clr_i && last;

      always_ff @(posedge clk) begin
         if (!rst_n)     cnt_q <= '0;
         else if (clr_i) cnt_q <= '0;
         else if (en_i)  cnt_q <= last ? '0 : cnt_q + 1'b1;
      end

      // R4: the divider count never passes the selected ratio
      a_r4_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
         cnt_q <= mask);
   end
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_val_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] nxt_o,
   output logic             hit_o
);
   logic [CNT_W-1:0] tmr_q;

   assign nxt_o = tmr_q + 1'b1;
   assign hit_o = tick_i && (tmr_q == period_i);

   always_ff @(posedge clk) begin
      if (!rst_n)      tmr_q <= '0;
      else if (ld_i)   tmr_q <= ld_val_i;
      else if (hit_o)  tmr_q <= '0;
      else if (tick_i) tmr_q <= nxt_o;
   end

   // R5: a period match returns the count to zero
   a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_o && !ld_i) |=> (tmr_q == '0));
   // R3: without a tick or a load the count holds
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !ld_i) |=> $stable(tmr_q));
endmodule

// File: rtl/pmt_postscaler.sv
module pmt_postscaler #(
   parameter int POST_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit_i,
   input  logic              clr_i,
   input  logic [POST_W-1:0] ratio_i,
   input  logic              irq_clr_i,
   output logic              irq_o
);
   logic [POST_W-1:0] cnt_q;
   logic              wrap;

   assign wrap = hit_i && (cnt_q == ratio_i);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else if (hit_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         irq_o <= 1'b0;
      else if (wrap)      irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
   end

   // R6: the match count stays within the selected ratio
   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= ratio_i);
   // R6: the flag rises only after a period match
   a_r6_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(hit_i));
   // R6: a clear without a match drops the flag
   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr_i && !hit_i) |=> !irq_o);
endmodule

// File: rtl/pmt_pwm.sv
module pmt_pwm #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             hit_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] nxt_i,
   input  logic [CNT_W-1:0] duty_i,
   output logic             pwm_o
);
   logic [CNT_W-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwm_o <= 1'b0;
         sh_q  <= '0;
      end else if (!en_i) begin
         pwm_o <= 1'b0;
      end else if (hit_i) begin
         pwm_o <= (duty_i != '0);
         sh_q  <= duty_i;
      end else if (tick_i && (nxt_i == sh_q)) begin
         pwm_o <= 1'b0;
      end
   end

   // R8: outside PWM mode the output is low
   a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !pwm_o);
   // R10: zero duty keeps the new cycle low
   a_r10_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && hit_i && duty_i == '0) |=> !pwm_o);
   // R9: the output rises only at a cycle start
   a_r9_rise_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_o) |-> $past(hit_i));
endmodule

// File: rtl/pmt_timer_pwm.sv
module pmt_timer_pwm #(
   parameter int CNT_W   = 8,
   parameter int DATA_W  = 8,
   parameter int POST_W  = 4,
   parameter int PRE_MAX = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              irq_clr,
   output logic              pwm_o,
   output logic              irq_o
);
   import pmt_pkg::*;

   localparam int CTL_W = CTL_POST_LSB + POST_W;

   if (CNT_W < 2) begin : g_chk_cnt
      $error("CNT_W must be at least 2");
   end
   if (DATA_W < CNT_W) begin : g_chk_data
      $error("DATA_W must hold a full count");
   end
   if (DATA_W < CTL_W) begin : g_chk_ctl
      $error("DATA_W too narrow for the control fields");
   end
   if (POST_W < 1) begin : g_chk_post
      $error("POST_W must be at least 1");
   end

   logic [CNT_W-1:0] period_q, duty_q, nxt;
   logic [CTL_W-1:0] ctrl_q;
   logic             pwm_on_q;
   logic             wr_period, wr_duty, wr_ctrl, wr_mode, wr_count;
   logic             tick, hit, pre_clr;

   assign wr_period = wr_en && (wr_sel == REG_PERIOD);
   assign wr_duty   = wr_en && (wr_sel == REG_DUTY);
   assign wr_ctrl   = wr_en && (wr_sel == REG_CTRL);
   assign wr_mode   = wr_en && (wr_sel == REG_MODE);
   assign wr_count  = wr_en && (wr_sel == REG_COUNT);
   assign pre_clr   = wr_ctrl || wr_count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_q <= '1;
         duty_q   <= '0;
         ctrl_q   <= '0;
         pwm_on_q <= 1'b0;
      end else begin
         if (wr_period) period_q <= wr_data[CNT_W-1:0];
         if (wr_duty)   duty_q   <= wr_data[CNT_W-1:0];
         if (wr_ctrl)   ctrl_q   <= wr_data[CTL_W-1:0];
         if (wr_mode)   pwm_on_q <= (wr_data[MODE_SEL_LSB +: 2] == 2'b11);
      end
   end

   pmt_prescaler #(.SEL_W(CTL_PRE_W), .STEP_LOG(2), .MAX_LOG(PRE_MAX)) u_pre (
      .clk(clk), .rst_n(rst_n), .en_i(ctrl_q[CTL_EN_BIT]), .clr_i(pre_clr),
      .sel_i(ctrl_q[CTL_PRE_LSB +: CTL_PRE_W]), .tick_o(tick));

   pmt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .ld_i(wr_count),
      .ld_val_i(wr_data[CNT_W-1:0]), .period_i(period_q),
      .nxt_o(nxt), .hit_o(hit));

   pmt_postscaler #(.POST_W(POST_W)) u_post (
      .clk(clk), .rst_n(rst_n), .hit_i(hit), .clr_i(pre_clr),
      .ratio_i(ctrl_q[CTL_POST_LSB +: POST_W]), .irq_clr_i(irq_clr),
      .irq_o(irq_o));

   pmt_pwm #(.CNT_W(CNT_W)) u_pwm (
      .clk(clk), .rst_n(rst_n), .en_i(pwm_on_q), .hit_i(hit), .tick_i(tick),
      .nxt_i(nxt), .duty_i(duty_q), .pwm_o(pwm_o));

   // R7: no tick in the cycle of a timer or control write
   a_r7_no_tick_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      pre_clr |-> !hit);
endmodule

// File: tb/pmt_timer_pwm_tb_top.sv
module pmt_timer_pwm_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'd0;
   logic       irq_clr = 1'b0;
   logic       pwm_o, irq_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   pmt_timer_pwm dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .irq_clr(irq_clr), .pwm_o(pwm_o), .irq_o(irq_o));

   task automatic chk(input int act, input int exp, input string req, input int k);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, k, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      wr_sel = s; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; wr_en = 1'b0; irq_clr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   function automatic logic [7:0] ctl(input int ps, input int en, input int pn);
      return 8'((pn << 3) | (en << 2) | ps);
   endfunction

   // R4 R5 R6 R9 R10 R11: sweep run, output predicted every clock
   task automatic run_cfg(input int p, input int ps, input int d, input int pn, input int d2);
      int dv, l, ph, m, du, ep, ei;
      dv = (ps == 0) ? 1 : (ps == 1) ? 4 : 16;
      l  = (p + 1) * dv;
      do_reset();
      wr(3'd0, 8'(p));
      wr(3'd1, 8'(d));
      wr(3'd3, (ps == 2) ? 8'h0F : 8'h0C);
      wr(3'd2, ctl(ps, 1, pn));
      wr(3'd4, 8'(p));
      for (int k = 1; k <= dv + 3 * l; k++) begin
         @(negedge clk);
         if (k < dv) begin
            ep = 0; ei = 0;
         end else begin
            ph = (k - dv) % l;
            m  = (k - dv) / l;
            du = (m > 0 && d2 >= 0) ? d2 : d;
            ep = (du != 0 && ph < du * dv) ? 1 : 0;
            ei = (m + 1 >= pn + 1) ? 1 : 0;
         end
         chk(int'(pwm_o), ep, (d2 >= 0) ? "R11 pwm" : "R9/R10 pwm (R4 R5)", k);
         chk(int'(irq_o), ei, "R6 flag", k);
         if (d2 >= 0 && k == dv + 1) begin
            wr_sel = 3'd1; wr_data = 8'(d2); wr_en = 1'b1;
         end
         if (k == dv + 2) wr_en = 1'b0;
      end
      wr(3'd2, ctl(ps, 0, pn));
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk(int'(irq_o), 0, "R6 clear", 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int pl[4];
      int dl[5];
      pl = '{0, 1, 2, 5};

      // R1: reset state and default period 255
      do_reset();
      chk(int'(pwm_o), 0, "R1 pwm", 0);
      chk(int'(irq_o), 0, "R1 flag", 0);
      wr(3'd2, ctl(0, 1, 0));
      for (int k = 1; k <= 257; k++) begin
         @(negedge clk);
         if (k >= 254) chk(int'(irq_o), (k >= 256) ? 1 : 0, "R1 default period", k);
      end

      // R2: unused select codes do not disturb a running PWM
      do_reset();
      wr(3'd0, 8'd3); wr(3'd1, 8'd4); wr(3'd3, 8'h0C);
      wr(3'd2, ctl(0, 1, 0)); wr(3'd4, 8'd3);
      wr(3'd5, 8'h00); wr(3'd6, 8'h00); wr(3'd7, 8'h00);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         chk(int'(pwm_o), 1, "R2 ignored selects", k);
      end

      // R3: disabled counting freezes the output mid-cycle
      do_reset();
      wr(3'd0, 8'd3); wr(3'd1, 8'd2); wr(3'd3, 8'h0C);
      wr(3'd2, ctl(0, 1, 0)); wr(3'd4, 8'd3);
      for (int k = 1; k <= 30; k++) begin
         @(negedge clk);
         chk(int'(pwm_o), 1, "R3 hold while disabled", k);
         if (k == 1) begin wr_sel = 3'd2; wr_data = ctl(0, 0, 0); wr_en = 1'b1; end
         if (k == 2) wr_en = 1'b0;
      end

      // R7: control write clears the postscaler
      do_reset();
      wr(3'd0, 8'd3); wr(3'd3, 8'h0C);
      wr(3'd2, ctl(0, 1, 1)); wr(3'd4, 8'd3);
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         chk(int'(irq_o), (k >= 10) ? 1 : 0, "R7 postscaler cleared", k);
         if (k == 2) begin wr_sel = 3'd2; wr_data = ctl(0, 1, 1); wr_en = 1'b1; end
         if (k == 3) wr_en = 1'b0;
      end

      // R8: leaving PWM mode forces the output low
      do_reset();
      wr(3'd0, 8'd3); wr(3'd1, 8'd4); wr(3'd3, 8'h0C);
      wr(3'd2, ctl(0, 1, 0)); wr(3'd4, 8'd3);
      for (int k = 1; k <= 20; k++) begin
         @(negedge clk);
         if (k <= 5) chk(int'(pwm_o), 1, "R8 before mode clear", k);
         else        chk(int'(pwm_o), 0, "R8 mode cleared", k);
         if (k == 4) begin wr_sel = 3'd3; wr_data = 8'h00; wr_en = 1'b1; end
         if (k == 5) wr_en = 1'b0;
      end
      wr(3'd3, 8'h0B);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk(int'(pwm_o), 0, "R8 non-PWM mode", k);
      end

      // R4 R5 R6 R9 R10: sweep
      foreach (pl[i]) begin
         dl = '{0, 1, pl[i], pl[i] + 1, pl[i] + 3};
         for (int ps = 0; ps < 3; ps++) begin
            foreach (dl[j]) run_cfg(pl[i], ps, dl[j], ((pl[i] + dl[j]) % 2) * 2, -1);
         end
      end

      // R11: duty change mid-cycle
      run_cfg(5, 1, 4, 0, 1);
      run_cfg(9, 0, 3, 0, 7);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule